// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block carries out a single read transaction on a 16-bit SDRAM whose address and data share one bus. A request supplies a row, a column, a halfword count and a mode bit. The sequencer opens the row, issues the column read with a fixed CAS latency of two, and releases the bus to the memory. It then returns each halfword on a strobed output and pulses a completion flag once chip select has been released.

There are two modes. The streaming mode accepts any count of one or more and cuts the burst short with a Burst Terminate command. It masks the data lanes one clock before it lets go of chip select. The short mode accepts only one or two halfwords, sends no terminate, and releases the lane masks and chip select in the same clock. A ready output holds off new requests while a transaction runs and for one idle clock after it. A request whose count is illegal for its mode raises an error pulse and is not run.

Top module: `sdram_rd_seq`

## Requirements
- R1: In the clock after a request is accepted (start and ready both high at a rising edge), chip select is low and the command is Activate, encoded (RAS_n,CAS_n,WE_n)=(0,1,1). The bus output enable is high and the bus carries the row, and it keeps the row in the following clock.
- R2: Two clocks after Activate the command is Read (1,0,1) with the column on the bus and output enable high. The clock between them is a NOP (1,1,1) with chip select low. Output enable is low from the clock after Read until the transaction ends.
- R3: The bus value present k clocks after the first data clock (Read + 2) appears on rd_data with rd_valid high one clock later, for k = 0..n-1. There are exactly n such strobes, rd_last is high with the final one only, and no bus value outside that window is captured.
- R4: In streaming mode (req_nb=1) Burst Terminate (1,1,0) is issued exactly n clocks after Read. For n=1 this is the NOP slot just before the first data clock.
- R5: In streaming mode both DQM lanes go to 2'b11 (masked) in the clock after the last data clock while chip select stays low, and chip select goes high one clock later. done is high for exactly that first chip-select-high clock.
- R6: In short mode (req_nb=0, n of 1 or 2) no Burst Terminate is issued. DQM returns to 2'b11 and chip select returns high in the same clock, the one after the last data clock, and done is high for that clock. DQM is 2'b00 throughout the rest of every transaction.
- R7: While idle, chip select is high, the command bits are (1,1,1), output enable is low, the bus output is zero and DQM is 2'b11. CKE is high whenever chip select is low.
- R8: ready is low from the clock after acceptance through the first chip-select-high clock, so at least one idle clock precedes the next Activate. A start raised while ready is low changes no output.
- R9: A request with a count of zero, or a short-mode request with a count above 2, pulses err for one clock. It produces no chip select activity and leaves ready high.
- R10: During and right after reset, chip select is high, the command is NOP, DQM is 2'b11, output enable, rd_valid, done and err are low, CKE is high and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when ready is high |
| req_row | input | 16 | Row address for Activate |
| req_col | input | 16 | Column address for Read |
| req_cnt | input | 8 | Halfword count n |
| req_nb | input | 1 | 1 = streaming mode with terminate, 0 = short mode |
| ready | output | 1 | Sequencer can accept a request |
| err | output | 1 | One-clock pulse for a rejected request |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe command bit |
| sd_cas_n | output | 1 | Column strobe command bit |
| sd_we_n | output | 1 | Write enable command bit |
| sd_dqm | output | 2 | Upper/lower lane masks, 1 = masked |
| sd_ad_out | output | 16 | Address value driven onto the shared bus |
| sd_ad_oe | output | 1 | Bus output enable |
| sd_ad_in | input | 16 | Value read from the shared bus |
| rd_data | output | 16 | Captured halfword |
| rd_valid | output | 1 | rd_data holds a new halfword |
| rd_last | output | 1 | Marks the final halfword |
| done | output | 1 | One-clock pulse when the transaction ends |

## Verification
The bench targets a one-halfword streaming read, where a sequencer placing the terminate at "n-2 after the data start" would emit it a cycle too late or not at all. It also covers the two short-mode counts, where a design reusing streaming release ordering would hold chip select one extra clock. The memory model keeps driving fresh values after the burst window, so an off-by-one capture window shows up as an extra strobe or shifted data. Back-to-back requests, a start pulsed mid-transaction, and illegal counts (zero, short mode with three) catch a sequencer that skips the idle clock, latches a request while busy, or runs a rejected one.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // command bits as (ras_n, cas_n, we_n), valid while chip select is low
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_ROW  = 2'd1,
    BUS_COL  = 2'd2
  } bus_sel_e;

  typedef struct packed {
    logic     cs_n;
    cmd_e     cmd;
    logic     oe;
    bus_sel_e sel;
    logic     mask;
  } pin_s;

  localparam int CAS_LAT  = 2;
  localparam int PH_RD    = 2;                // Read phase after Activate
  localparam int PH_DATA0 = PH_RD + CAS_LAT;  // first data phase

endpackage

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  parameter int PH_W  = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    req_row,
  input  logic [DW-1:0]    req_col,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             req_nb,
  output logic             ready,
  output logic             err,
  output logic             done,
  output logic             act_q,
  output logic [PH_W-1:0]  ph_q,
  output logic [CNT_W-1:0] n_q,
  output logic             nb_q,
  output logic             nxt_act,
  output logic [PH_W-1:0]  nxt_ph,
  output logic [CNT_W-1:0] nxt_n,
  output logic             nxt_nb,
  output logic [DW-1:0]    nxt_row,
  output logic [DW-1:0]    nxt_col
);

  logic            gap_q;
  logic [DW-1:0]   row_q, col_q;
  logic            req_ok, accept, at_end;
  logic [PH_W-1:0] last_ph;

  assign ready   = !act_q && !gap_q;
  assign req_ok  = (req_cnt != '0) && (req_nb || (req_cnt <= CNT_W'(2)));
  assign accept  = start && ready && req_ok;
  assign last_ph = PH_W'(n_q) + (nb_q ? PH_W'(PH_DATA0) : PH_W'(PH_DATA0 - 1));
  assign at_end  = act_q && (ph_q == last_ph);

  always_comb begin
    nxt_act = act_q;
    nxt_ph  = ph_q;
    nxt_n   = n_q;
    nxt_nb  = nb_q;
    nxt_row = row_q;
    nxt_col = col_q;
    if (accept) begin
      nxt_act = 1'b1;
      nxt_ph  = '0;
      nxt_n   = req_cnt;
      nxt_nb  = req_nb;
      nxt_row = req_row;
      nxt_col = req_col;
    end else if (at_end) begin
      nxt_act = 1'b0;
      nxt_ph  = '0;
    end else if (act_q) begin
      nxt_ph  = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      gap_q <= 1'b0;
      ph_q  <= '0;
      n_q   <= '0;
      nb_q  <= 1'b0;
      row_q <= '0;
      col_q <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      act_q <= nxt_act;
      ph_q  <= nxt_ph;
      n_q   <= nxt_n;
      nb_q  <= nxt_nb;
      row_q <= nxt_row;
      col_q <= nxt_col;
      gap_q <= at_end;
      done  <= at_end;
      err   <= start && ready && !req_ok;
    end
  end

  // R9: a rejected request never opens a transaction
  a_r9_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (start && ready && !req_ok) |=> !act_q);

  // R8: the clock after the final phase is never ready
  a_r8_idle_clock: assert property (@(posedge clk) disable iff (rst)
    at_end |=> !ready);

endmodule

// File: rtl/sdram_rd_decode.sv
module sdram_rd_decode
  import sdram_rd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PH_W  = CNT_W + 3
) (
  input  logic             act,
  input  logic [PH_W-1:0]  ph,
  input  logic [CNT_W-1:0] n,
  input  logic             nb,
  output pin_s             pins
);

  logic [PH_W-1:0] bst_ph, mask_ph;

  assign bst_ph  = PH_W'(n) + PH_W'(PH_RD);
  assign mask_ph = PH_W'(n) + PH_W'(PH_DATA0);

  always_comb begin
    pins.cs_n = 1'b1;
    pins.cmd  = CMD_NOP;
    pins.oe   = 1'b0;
    pins.sel  = BUS_NONE;
    pins.mask = 1'b1;
    if (act) begin
      pins.cs_n = 1'b0;
      pins.mask = nb && (ph == mask_ph);
      if (ph == '0)
        pins.cmd = CMD_ACT;
      else if (ph == PH_W'(PH_RD))
        pins.cmd = CMD_RD;
      else if (nb && (ph == bst_ph))
        pins.cmd = CMD_BST;
      pins.oe = (ph <= PH_W'(PH_RD));
      if (ph < PH_W'(PH_RD))
        pins.sel = BUS_ROW;
      else if (ph == PH_W'(PH_RD))
        pins.sel = BUS_COL;
    end
  end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
  import sdram_rd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  parameter int PH_W  = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic [PH_W-1:0]  ph,
  input  logic [CNT_W-1:0] n,
  input  logic [DW-1:0]    bus_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             rd_last
);

  logic            in_win;
  logic [PH_W-1:0] win_end;

  assign win_end = PH_W'(n) + PH_W'(PH_DATA0);
  assign in_win  = act && (ph >= PH_W'(PH_DATA0)) && (ph < win_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= in_win;
      rd_last  <= in_win && (ph == win_end - PH_W'(1));
      if (in_win) rd_data <= bus_in;
    end
  end

  // R3: a last strobe is only ever one of the valid strobes
  a_r3_last_marks_valid: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  // R3: captures come only from a transaction that was open a clock earlier
  a_r3_capture_in_txn: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(act));

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    req_row,
  input  logic [DW-1:0]    req_col,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             req_nb,
  output logic             ready,
  output logic             err,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [1:0]       sd_dqm,
  output logic [DW-1:0]    sd_ad_out,
  output logic             sd_ad_oe,
  input  logic [DW-1:0]    sd_ad_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             rd_last,
  output logic             done
);

  localparam int PH_W = CNT_W + 3;

  logic             act_q, nb_q, nxt_act, nxt_nb;
  logic [PH_W-1:0]  ph_q, nxt_ph;
  logic [CNT_W-1:0] n_q, nxt_n;
  logic [DW-1:0]    nxt_row, nxt_col;
  pin_s             nxt_pins;

  sdram_rd_ctrl #(.DW(DW), .CNT_W(CNT_W), .PH_W(PH_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .req_row(req_row), .req_col(req_col), .req_cnt(req_cnt), .req_nb(req_nb),
    .ready(ready), .err(err), .done(done),
    .act_q(act_q), .ph_q(ph_q), .n_q(n_q), .nb_q(nb_q),
    .nxt_act(nxt_act), .nxt_ph(nxt_ph), .nxt_n(nxt_n), .nxt_nb(nxt_nb),
    .nxt_row(nxt_row), .nxt_col(nxt_col)
  );

  sdram_rd_decode #(.CNT_W(CNT_W), .PH_W(PH_W)) u_dec (
    .act(nxt_act), .ph(nxt_ph), .n(nxt_n), .nb(nxt_nb), .pins(nxt_pins)
  );

  sdram_rd_capture #(.DW(DW), .CNT_W(CNT_W), .PH_W(PH_W)) u_cap (
    .clk(clk), .rst(rst), .act(act_q), .ph(ph_q), .n(n_q),
    .bus_in(sd_ad_in), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last)
  );

  // registered pin stage
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cke    <= 1'b1;
      sd_cs_n   <= 1'b1;
      sd_ras_n  <= 1'b1;
      sd_cas_n  <= 1'b1;
      sd_we_n   <= 1'b1;
      sd_dqm    <= 2'b11;
      sd_ad_out <= '0;
      sd_ad_oe  <= 1'b0;
    end else begin
      sd_cke    <= 1'b1;
      sd_cs_n   <= nxt_pins.cs_n;
      {sd_ras_n, sd_cas_n, sd_we_n} <= nxt_pins.cmd;
      sd_dqm    <= {2{nxt_pins.mask}};
      sd_ad_oe  <= nxt_pins.oe;
      case (nxt_pins.sel)
        BUS_ROW: sd_ad_out <= nxt_row;
        BUS_COL: sd_ad_out <= nxt_col;
        default: sd_ad_out <= '0;
      endcase
    end
  end

  logic is_act, is_rd, is_bst;
  assign is_act = !sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_ACT);
  assign is_rd  = !sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_RD);
  assign is_bst = !sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} == CMD_BST);

  a_r2_read_follows_act: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> $past(is_act, 2));

  a_r2_nop_between: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> (!$past(sd_cs_n) && $past(sd_ras_n) && $past(sd_cas_n) && $past(sd_we_n)));

  a_r2_bus_released: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> !sd_ad_oe);

  a_r6_no_bst_short: assert property (@(posedge clk) disable iff (rst)
    is_bst |-> nb_q);

  a_r5_mask_before_cs: assert property (@(posedge clk) disable iff (rst)
    ($rose(sd_cs_n) && nb_q) |-> ($past(sd_dqm) == 2'b11));

  a_r6_mask_with_cs: assert property (@(posedge clk) disable iff (rst)
    ($rose(sd_cs_n) && !nb_q) |-> ($past(sd_dqm) == 2'b00));

  a_r7_cke_high: assert property (@(posedge clk) disable iff (rst)
    !sd_cs_n |-> sd_cke);

  a_r8_gap_before_act: assert property (@(posedge clk) disable iff (rst)
    $fell(sd_cs_n) |-> $past(sd_cs_n, 2));

  a_r9_err_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    err |-> (sd_cs_n && ready));

endmodule

// File: tb/sdram_rd_seq_tb.sv
module sdram_rd_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] req_row = '0, req_col = '0;
  logic [7:0]  req_cnt = '0;
  logic        req_nb = 1'b0;
  logic        ready, err, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ad_oe;
  logic [1:0]  sd_dqm;
  logic [15:0] sd_ad_out, rd_data;
  logic [15:0] sd_ad_in = '0;
  logic        rd_valid, rd_last, done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sdram_rd_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .req_row(req_row), .req_col(req_col),
    .req_cnt(req_cnt), .req_nb(req_nb), .ready(ready), .err(err),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_dqm(sd_dqm), .sd_ad_out(sd_ad_out), .sd_ad_oe(sd_ad_oe),
    .sd_ad_in(sd_ad_in), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          rc = -1;
  int          mn = 0;
  int          gap = 0;
  bit          mnb = 0;
  logic [15:0] mrow, mcol, mbase;
  bit          e_done = 0, e_err = 0;
  logic [16:0] capq[$];

  always @(negedge clk) begin
    if (rst) begin
      rc = -1; gap = 0; e_done = 0; e_err = 0; capq.delete();
    end else begin
      bit act, rdy, okreq, acc, nxt_done, nxt_err, e_oe, e_v, e_l;
      int last_rc;
      logic [2:0] e_cmd;
      logic [1:0] e_dqm;
      logic [15:0] e_addr, e_d;
      string tmode, tcmd;
      act = (rc >= 0);
      last_rc = mnb ? 4 + mn : 3 + mn;
      rdy = !act && (gap == 0);
      e_cmd = 3'b111;
      if (act && rc == 0) e_cmd = 3'b011;
      else if (act && rc == 2) e_cmd = 3'b101;
      else if (act && mnb && rc == mn + 2) e_cmd = 3'b110;
      e_oe = act && rc <= 2;
      e_addr = !act ? 16'h0 : (rc <= 1) ? mrow : (rc == 2) ? mcol : 16'h0;
      e_dqm = (act && !(mnb && rc == 4 + mn)) ? 2'b00 : 2'b11;
      tmode = mnb ? "R5" : "R6";
      tcmd = !act ? "R7" : (rc == 0) ? "R1" : (rc == 2) ? "R2" : mnb ? "R4" : "R6";
      e_v = 0; e_l = 0; e_d = 'x;
      if (capq.size() > 0) begin
        logic [16:0] ent;
        ent = capq.pop_front();
        e_v = 1; e_l = ent[16]; e_d = ent[15:0];
      end
      chk(sd_cs_n == !act, act ? tmode : "R7", "cs_n", sd_cs_n, !act);
      chk({sd_ras_n, sd_cas_n, sd_we_n} == e_cmd, tcmd, "cmd",
          {sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
      chk(sd_ad_oe == e_oe, (rc <= 1) ? "R1" : "R2", "oe", sd_ad_oe, e_oe);
      chk(sd_ad_out == e_addr, (rc <= 1) ? "R1" : "R2", "bus out", sd_ad_out, e_addr);
      chk(sd_dqm == e_dqm, tmode, "dqm", sd_dqm, e_dqm);
      chk(!act || sd_cke, "R7", "cke", sd_cke, 1);
      chk(rd_valid == e_v, "R3", "rd_valid", rd_valid, e_v);
      if (e_v) begin
        chk(rd_data == e_d, "R3", "rd_data", rd_data, e_d);
        chk(rd_last == e_l, "R3", "rd_last", rd_last, e_l);
      end
      chk(done == e_done, tmode, "done", done, e_done);
      chk(ready == rdy, "R8", "ready", ready, rdy);
      chk(err == e_err, "R9", "err", err, e_err);
      // memory keeps streaming from the first data clock onward
      sd_ad_in = (act && rc >= 4) ? mbase + 16'(rc - 4) : 16'h0;
      if (act && rc >= 4 && rc <= 3 + mn)
        capq.push_back({rc == 3 + mn, mbase + 16'(rc - 4)});
      okreq = (req_cnt != 0) && (req_nb || req_cnt <= 2);
      acc = start && rdy && okreq;
      nxt_err = start && rdy && !okreq;
      nxt_done = act && rc == last_rc;
      if (act) begin
        if (rc == last_rc) begin rc = -1; gap = 1; end
        else rc++;
      end else gap = 0;
      if (acc) begin
        rc = 0; mn = req_cnt; mnb = req_nb; mrow = req_row; mcol = req_col;
        mbase = req_row ^ req_col;
      end
      e_done = nxt_done;
      e_err = nxt_err;
    end
  end

  task automatic issue(input logic [15:0] row, input logic [15:0] col,
                       input int n, input bit nb);
    bit r;
    @(posedge clk); #2;
    start = 1; req_row = row; req_col = col; req_cnt = 8'(n); req_nb = nb;
    forever begin
      @(negedge clk); r = ready;
      @(posedge clk); #2;
      if (r) break;
    end
    start = 0;
  endtask

  task automatic poke();
    @(posedge clk); #2;
    start = 1; req_row = 16'hDEAD; req_col = 16'hBEEF; req_cnt = 8'd5; req_nb = 1;
    @(posedge clk); #2;
    start = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: values held during reset
    chk(sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n, "R10", "idle pins in reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hf);
    chk(sd_dqm == 2'b11 && !sd_ad_oe && sd_cke, "R10", "dqm/oe/cke in reset",
        {sd_dqm, sd_ad_oe, sd_cke}, 4'b1101);
    @(posedge clk); #2; rst = 0;
    @(negedge clk);
    chk(ready && !rd_valid && !done && !err, "R10", "ready/valid/done/err after reset",
        {ready, rd_valid, done, err}, 4'b1000);

    issue(16'h1234, 16'h0040, 1, 1);   // streaming, single halfword
    repeat (8) @(posedge clk);
    issue(16'h2001, 16'h0011, 2, 1);
    repeat (8) @(posedge clk);
    issue(16'h3ABC, 16'h0102, 3, 1);
    repeat (9) @(posedge clk);
    issue(16'h4F0F, 16'h00F0, 8, 1);
    repeat (14) @(posedge clk);
    issue(16'h5555, 16'h0003, 1, 0);   // short mode
    repeat (8) @(posedge clk);
    issue(16'h6666, 16'h0007, 2, 0);
    repeat (8) @(posedge clk);
    issue(16'h7777, 16'h0001, 3, 0);   // R9: illegal short count
    repeat (3) @(posedge clk);
    issue(16'h7778, 16'h0002, 0, 1);   // R9: zero count
    repeat (3) @(posedge clk);
    issue(16'h8000, 16'h0100, 2, 1);   // back to back
    issue(16'h8001, 16'h0200, 1, 0);
    issue(16'h8002, 16'h0300, 4, 1);
    repeat (10) @(posedge clk);
    issue(16'h9000, 16'h0ABC, 20, 1);  // R8: start while busy is ignored
    repeat (3) @(posedge clk);
    poke();
    repeat (6) @(posedge clk);
    poke();
    repeat (30) @(posedge clk);
    issue(16'hA5A5, 16'h5A5A, 40, 1);
    repeat (60) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule